// File: doc/BRIEF.md
# End-of-Write Status Read Multiplexer

This block picks the byte a memory model hands back on each read. When no internal programming cycle is running, it passes the stored array byte through unchanged. While the write engine reports busy, it returns a status byte instead. A host can therefore poll any location and learn when programming has finished. Two busy indications are carried inside the data byte. The top bit is the inverse of the top bit of the byte most recently written. The bit below it flips from one read access to the next. The remaining bits mirror the last written byte.

A read access starts on a clock edge that samples the read strobe high after it was low. It lasts for as long as the strobe stays high. A small state machine tracks this with two states, `RS_QUIET` (strobe low) and `RS_ACTIVE` (strobe high). It has two named transitions: `open`, from `RS_QUIET` to `RS_ACTIVE` when the strobe is seen high, and `close`, from `RS_ACTIVE` to `RS_QUIET` when the strobe is seen low. Each `open` taken while busy advances a toggle flop. The output byte is registered, so it appears one clock after the inputs it depends on are sampled. The bus reads zero when no access is active. Busy periods started by a write that was refused for lack of an unlock sequence look the same on the busy input and give the same status reads.

Top module: `eow_status_read`

## Requirements
- R1: While reset is asserted, the read data output is 0x00 and the sequencer is in `RS_QUIET`.
- R2: One clock after an edge that samples the read strobe low, the read data output is 0x00.
- R3: One clock after an edge that samples the strobe high and busy low, the output equals the array byte sampled at that edge, on all eight bits.
- R4: One clock after an edge that samples both strobe and busy high, output bit 7 is the inverse of bit 7 of the last written byte sampled at that edge.
- R5: Under the same condition as R4, output bits 5 to 0 equal bits 5 to 0 of the sampled last written byte.
- R6: Under the same condition as R4, output bit 6 takes the opposite value on each new access (`open` while busy) from the previous busy access. It stays constant for the whole of one access. Its value after reset is not defined.
- R7: Accesses made while busy is low do not advance the toggle. The first busy access after an idle period shows bit 6 opposite to the last busy access before that period.
- R8: If busy rises while an access is already active, the output switches to the status byte one clock later. Bit 6 keeps the value of the last busy access, because no `open` occurred.
- R9: If busy falls while an access is active, the output returns to the array byte one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb_i | input | 1 | Read strobe; high for the length of an access |
| busy_i | input | 1 | Internal write cycle in progress |
| last_wr_i | input | DATA_W | Byte most recently written |
| arr_rdata_i | input | DATA_W | Byte read from the array at the current address |
| rd_data_o | output | DATA_W | Registered read data |

## Verification
A sequencer stuck in `RS_ACTIVE` or `RS_QUIET` would show up at the next access. Bit 6 would then either fail to flip between two busy reads or flip inside one held read. Either fault is visible on the second busy access after it occurs. A toggle flop that advanced on idle reads would break the alternation across an idle gap on the first busy read after that gap. Errors in the mux select show up one clock after the strobe or busy edge that exposes them, as the wrong byte source or a missing inversion of bit 7.

// File: rtl/eow_pkg.sv
package eow_pkg;

    typedef enum logic {
        RS_QUIET  = 1'b0,
        RS_ACTIVE = 1'b1
    } rd_state_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

endpackage

// File: rtl/eow_rd_seq.sv
module eow_rd_seq
    import eow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb_i,
    output logic open_o,
    output logic active_o
);

    rd_state_e state_q;
    rd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_QUIET:  if (rd_stb_i)  state_d = RS_ACTIVE;
            RS_ACTIVE: if (!rd_stb_i) state_d = RS_QUIET;
            default:                  state_d = RS_QUIET;
        endcase
    end

    always_comb begin
        open_o   = 1'b0;
        active_o = 1'b0;
        unique case (state_q)
            RS_QUIET:  open_o   = rd_stb_i;
            RS_ACTIVE: active_o = 1'b1;
            default:   open_o   = 1'b0;
        endcase
    end

    AST_SEQ_RESET: assert property (@(posedge clk)
        !rst_n |-> state_q == RS_QUIET); // R1

endmodule

// File: rtl/eow_tgl_reg.sv
module eow_tgl_reg #(
    parameter logic TGL_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic tgl_nxt_o
);

    logic tgl_q;

    always_comb begin
        tgl_nxt_o = adv_i ? ~tgl_q : tgl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= TGL_INIT;
        end else begin
            tgl_q <= tgl_nxt_o;
        end
    end

endmodule

// File: rtl/eow_out_mux.sv
module eow_out_mux
    import eow_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_i,
    input  logic              busy_i,
    input  logic              tgl_i,
    input  logic [DATA_W-1:0] last_wr_i,
    input  logic [DATA_W-1:0] arr_rdata_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int FLAG_POS = DATA_W - 1;
    localparam int TGL_POS  = DATA_W - 2;

    rd_src_e           src;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] data_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        if (!rd_stb_i)   src = SRC_NONE;
        else if (busy_i) src = SRC_STATUS;
        else             src = SRC_ARRAY;
    end

    always_comb begin
        status_w           = last_wr_i;
        status_w[FLAG_POS] = ~last_wr_i[FLAG_POS];
        status_w[TGL_POS]  = tgl_i;
    end

    always_comb begin
        unique case (src)
            SRC_ARRAY:  data_d = arr_rdata_i;
            SRC_STATUS: data_d = status_w;
            default:    data_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign rd_data_o = data_q;

endmodule

// File: rtl/eow_status_read.sv
module eow_status_read #(
    parameter int   DATA_W   = 8,
    parameter logic TGL_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] last_wr_i,
    input  logic [DATA_W-1:0] arr_rdata_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int FLAG_POS = DATA_W - 1;
    localparam int TGL_POS  = DATA_W - 2;
    localparam int LOW_TOP  = DATA_W - 3;

    logic open_w;
    logic active_w;
    logic adv_w;
    logic tgl_nxt_w;

    eow_rd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb_i (rd_stb_i),
        .open_o   (open_w),
        .active_o (active_w)
    );

    assign adv_w = open_w & busy_i;

    eow_tgl_reg #(.TGL_INIT(TGL_INIT)) u_tgl (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv_w),
        .tgl_nxt_o (tgl_nxt_w)
    );

    eow_out_mux #(.DATA_W(DATA_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_stb_i    (rd_stb_i),
        .busy_i      (busy_i),
        .tgl_i       (tgl_nxt_w),
        .last_wr_i   (last_wr_i),
        .arr_rdata_i (arr_rdata_i),
        .rd_data_o   (rd_data_o)
    );

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_stb_i)) |-> rd_data_o == '0); // R2

    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_stb_i && !busy_i)) |-> rd_data_o == $past(arr_rdata_i)); // R3

    AST_FLAG_INV: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_stb_i && busy_i))
            |-> rd_data_o[FLAG_POS] == ~$past(last_wr_i[FLAG_POS])); // R4

    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_stb_i && busy_i))
            |-> rd_data_o[LOW_TOP:0] == $past(last_wr_i[LOW_TOP:0])); // R5

    AST_TGL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && active_w && rd_stb_i && busy_i && $past(rd_stb_i && busy_i))
            |=> rd_data_o[TGL_POS] == $past(rd_data_o[TGL_POS])); // R6

    AST_ACTIVE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_stb_i)) |-> active_w); // R8

endmodule

// File: tb/eow_status_read_bench.sv
module eow_status_read_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       stb;
    logic       busy;
    logic [7:0] last;
    logic [7:0] arr;
    logic [7:0] rdata;

    int errs   = 0;
    int checks = 0;
    bit prev_stb = 1'b0;
    int tgl_model = -1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    eow_status_read u_eow_status_read (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_stb_i    (stb),
        .busy_i      (busy),
        .last_wr_i   (last),
        .arr_rdata_i (arr),
        .rd_data_o   (rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit s, input bit b, input logic [7:0] l,
                       input logic [7:0] a, input string req);
        logic [7:0] exp;
        bit wild;
        stb = s; busy = b; last = l; arr = a;
        wild = 1'b0;
        if (s && b && !prev_stb && tgl_model >= 0) tgl_model = 1 - tgl_model;
        if (!s)      exp = 8'h00;
        else if (!b) exp = a;
        else begin
            exp = {~l[7], 1'b0, l[5:0]};
            if (tgl_model < 0) wild = 1'b1;
            else exp[6] = tgl_model[0];
        end
        prev_stb = s;
        @(posedge clk);
        #2;
        if (wild) begin
            exp[6] = rdata[6];
            tgl_model = int'(rdata[6]);
        end
        check(req, rdata, exp);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stb = 1'b1; busy = 1'b1; last = 8'hFF; arr = 8'h77;
        repeat (3) @(posedge clk);
        #2;
        check("R1", rdata, 8'h00);
        stb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1", rdata, 8'h00);

        // Idle reads: array pass-through and quiet bus
        cyc(1, 0, 8'h00, 8'h3C, "R3");
        cyc(1, 0, 8'h00, 8'hC3, "R3");
        cyc(0, 0, 8'h00, 8'h55, "R2");
        cyc(1, 0, 8'h00, 8'hFF, "R3");
        cyc(0, 0, 8'h00, 8'hAA, "R2");

        // Busy: status reads, alternating bit 6, held within one access
        cyc(1, 1, 8'hA5, 8'h11, "R4");
        cyc(1, 1, 8'hA5, 8'h11, "R6");
        cyc(1, 1, 8'h5A, 8'h11, "R5");
        cyc(0, 1, 8'h5A, 8'h11, "R2");
        for (int i = 0; i < 8; i++) begin
            cyc(1, 1, 8'(i * 37 + 3), 8'h22, "R6");
            cyc(1, 1, 8'(i * 37 + 3), 8'h22, "R5");
            cyc(0, 1, 8'(i * 37 + 3), 8'h22, "R2");
        end

        // Busy falls mid-access
        cyc(1, 1, 8'h80, 8'h40, "R4");
        cyc(1, 0, 8'h80, 8'h40, "R9");
        cyc(0, 0, 8'h80, 8'h40, "R2");

        // Idle reads must not advance the toggle
        for (int i = 0; i < 5; i++) begin
            cyc(1, 0, 8'h80, 8'(8'h40 ^ i), "R7");
            cyc(0, 0, 8'h80, 8'h00, "R2");
        end
        cyc(1, 1, 8'h7F, 8'h00, "R7");
        cyc(0, 1, 8'h7F, 8'h00, "R2");
        cyc(0, 0, 8'h7F, 8'h00, "R2");

        // Busy rises during an access already open
        cyc(1, 0, 8'h0F, 8'h99, "R3");
        cyc(1, 1, 8'h0F, 8'h99, "R8");
        cyc(1, 1, 8'hF0, 8'h99, "R8");
        cyc(0, 1, 8'hF0, 8'h99, "R2");
        cyc(1, 1, 8'hF0, 8'h99, "R6");
        cyc(0, 0, 8'hF0, 8'h99, "R2");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule